// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Timed Mutual Clear

This block compares the rising edges of a reference clock and a feedback clock and reports which one came first. Both clocks are treated as ordinary data inputs: each passes through a synchronizer clocked by a much faster system clock. A rising edge is then recognised as a low sample followed by a high sample. Each detected edge sets its own pending flag. The reference flag drives `up` and the feedback flag drives `dn`. A lead of the reference therefore shows as `up` running ahead of `dn`, and a lead of the feedback shows the other way round. The width of the lone pulse grows with the phase error.

When both flags are set, a small timer holds them high together for a programmable number of extra system cycles and then clears both in the same cycle. Even a zero phase error therefore yields a visible pair of pulses that a downstream pump or digital loop filter can act on, so no dead zone exists near lock. A one-cycle strobe marks each comparison that had a definite winner. An elaboration option decides whether an input that is already high when reset is released counts as a first edge, so that the loop responds at once after start-up.

Top module: `pfd_delayed_clear`

## Requirements
- R1: While reset is asserted and in the first cycle after release with both inputs low, `up`, `dn`, `lead_stb` and `lag_stb` are 0.
- R2: When the reference edge is detected k > 0 cycles before the feedback edge, `up` goes high k cycles before `dn`, and it stays high until the common clear.
- R3: When the feedback edge is detected k > 0 cycles before the reference edge, `dn` goes high k cycles before `up`, and it stays high until the common clear.
- R4: Once `up` and `dn` are both high, they stay high together for exactly `clr_dly`+1 cycles and then both drop in the same cycle.
- R5: With `clr_dly` = 0 the overlap lasts a single cycle: the clear takes effect on the cycle after both are first seen high.
- R6: Edges detected in the same cycle raise `up` and `dn` together, and neither strobe is produced.
- R7: `lead_stb` is high for exactly one cycle, the first cycle in which `dn` is high after `up` led. `lag_stb` is high for exactly one cycle, the first cycle in which `up` is high after `dn` led. Each strobe is seen only while both outputs are high.
- R8: A second reference edge that arrives while `up` is already pending and before the feedback edge is ignored. After the clear, `up` stays low until a later reference edge.
- R9: An input that goes high is first sampled at some system clock edge. The matching output goes high after the third system clock edge that samples the input high.
- R10: With `PRIME_FIRST` = 1 (the default), an input that is already high when reset is released counts as a rising edge and sets its output.
- R11: An input held high produces only one edge. After the clear, the outputs stay low until the input has gone low and high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_in | input | 1 | Feedback clock, asynchronous to clk |
| clr_dly | input | DLY_W (4) | Extra overlap cycles before the mutual clear |
| up | output | 1 | Reference edge pending |
| dn | output | 1 | Feedback edge pending |
| lead_stb | output | 1 | One-cycle mark: reference led this comparison |
| lag_stb | output | 1 | One-cycle mark: feedback led this comparison |

## Verification
A corrupted pending flag shows at the ports in two ways. A lone `up` or `dn` can fall without its partner, or an output can rise again after the clear without any new edge; either shows within one cycle. A wrong overlap counter shows as an overlap one or more cycles too short or too long, and this is seen on the very first comparison for any setting of `clr_dly`. A wrong strobe decision shows as a strobe on a tie, a missing strobe, or a strobe on the wrong side at the cycle the late output rises. Every sampled cycle of every comparison is therefore compared against the expected waveform.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // One bit per compared input, used for edge and flag pairs.
   typedef struct packed {
      logic refp;
      logic fbp;
   } pfd_pair_t;

   localparam int unsigned PFD_DLY_W_DEF  = 4;
   localparam int unsigned PFD_STAGES_DEF = 2;

   function automatic logic pair_both(input pfd_pair_t p);
      return p.refp & p.fbp;
   endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int unsigned STAGES      = 2,
   parameter bit          PRIME_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic rise_o
);

   // Primed: the chain resets low, so a level already high counts as an edge.
   // Unprimed: the chain resets high, so only a real low-to-high change counts.
   localparam logic RST_LVL = PRIME_FIRST ? 1'b0 : 1'b1;

   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pfd_edge_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_LVL;
            else        chain[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_LVL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= RST_LVL;
      else        last_q <= chain[STAGES-1];
   end

   assign rise_o = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/pfd_phase_latch.sv
module pfd_phase_latch
   import pfd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pfd_pair_t rise_i,
   input  logic      clr_i,
   output pfd_pair_t flag_o,
   output logic      lead_o,
   output logic      lag_o
);

   pfd_pair_t flag_q;
   logic      lead_q;
   logic      lag_q;

   // A rise while the flag is already set changes nothing, so one pending edge per side.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         lead_q <= 1'b0;
         lag_q  <= 1'b0;
      end else begin
         flag_q.refp <= rise_i.refp | (flag_q.refp & ~clr_i);
         flag_q.fbp  <= rise_i.fbp  | (flag_q.fbp  & ~clr_i);
         lead_q      <= flag_q.refp & ~flag_q.fbp  & rise_i.fbp;
         lag_q       <= flag_q.fbp  & ~flag_q.refp & rise_i.refp;
      end
   end

   assign flag_o = flag_q;
   assign lead_o = lead_q;
   assign lag_o  = lag_q;

endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer
   import pfd_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pfd_pair_t        flag_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             clr_o
);

   logic [DLY_W-1:0] cnt_q;
   logic             both;

   if (DLY_W < 1) begin : g_bad_w
      $error("pfd_clear_timer: DLY_W must be at least 1");
   end

   assign both  = pair_both(flag_i);
   assign clr_o = both & (cnt_q == dly_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr_o || !both) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/pfd_delayed_clear.sv
module pfd_delayed_clear
   import pfd_pkg::*;
#(
   parameter int unsigned DLY_W       = PFD_DLY_W_DEF,
   parameter int unsigned STAGES      = PFD_STAGES_DEF,
   parameter bit          PRIME_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             fb_in,
   input  logic [DLY_W-1:0] clr_dly,
   output logic             up,
   output logic             dn,
   output logic             lead_stb,
   output logic             lag_stb
);

   pfd_pair_t rise;
   pfd_pair_t flag;
   logic      clr;

   pfd_edge_sync #(.STAGES(STAGES), .PRIME_FIRST(PRIME_FIRST)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .d_in(ref_in), .rise_o(rise.refp)
   );

   pfd_edge_sync #(.STAGES(STAGES), .PRIME_FIRST(PRIME_FIRST)) u_fb_sync (
      .clk(clk), .rst_n(rst_n), .d_in(fb_in), .rise_o(rise.fbp)
   );

   pfd_phase_latch u_latch (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr),
      .flag_o(flag), .lead_o(lead_stb), .lag_o(lag_stb)
   );

   pfd_clear_timer #(.DLY_W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .flag_i(flag), .dly_i(clr_dly), .clr_o(clr)
   );

   assign up = flag.refp;
   assign dn = flag.fbp;

   // R2
   up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !dn) |=> up);

   // R3
   dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up) |=> dn);

   // R4
   joint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && dn && clr && !rise.refp && !rise.fbp) |=> (!up && !dn));

   // R7
   lead_in_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (up && dn));

   // R7
   lag_in_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lag_stb |-> (up && dn));

   // R7
   lead_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |=> !lead_stb);

   // R7
   lag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lag_stb |=> !lag_stb);

endmodule

// File: tb/pfd_delayed_clear_test.sv
module pfd_delayed_clear_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       fb_in = 1'b0;
   logic [3:0] clr_dly = 4'd0;
   logic       up, dn, lead_stb, lag_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfd_delayed_clear uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .clr_dly(clr_dly), .up(up), .dn(dn), .lead_stb(lead_stb), .lag_stb(lag_stb)
   );

   // Expected {up,dn,lead,lag} at observation j; r and f are the first
   // observations with each output high, d the clear delay.
   function automatic logic [3:0] exp_bits(int j, int r, int f, int d);
      int s;
      logic eu, ed, el, eg;
      s  = (r > f) ? r : f;
      eu = (j >= r) && (j <= s + d);
      ed = (j >= f) && (j <= s + d);
      el = (r < f) && (j == f);
      eg = (f < r) && (j == r);
      return {eu, ed, el, eg};
   endfunction

   task automatic check(string tag, logic [3:0] got, logic [3:0] exp, int cyc);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: up/dn/lead/lag got %b expected %b", tag, cyc, got, exp);
      end
   endtask

   // ro/fo: drive cycle of the reference/feedback rise; ro2 > 0 adds a
   // second reference rise after a two-cycle high pulse.
   task automatic run_case(int ro, int fo, int d, int ro2, string tag_in);
      string tag;
      int r, f;
      r = ro + 3;
      f = fo + 3;
      if (tag_in != "")  tag = tag_in;
      else if (r < f)    tag = "R2";
      else if (f < r)    tag = "R3";
      else               tag = "R6";
      clr_dly = d[3:0];
      for (int j = 0; j < 32; j++) begin
         @(negedge clk);
         check(tag, {up, dn, lead_stb, lag_stb}, exp_bits(j, r, f, d), j);
         if (ro2 > 0) ref_in = ((j >= ro) && (j < ro + 2)) || (j >= ro2);
         else         ref_in = (j >= ro);
         fb_in = (j >= fo);
      end
      @(negedge clk);
      ref_in = 1'b0;
      fb_in  = 1'b0;
      repeat (6) @(negedge clk);
      check("R11", {up, dn, lead_stb, lag_stb}, 4'b0000, 99);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: got running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int dummy;
      int ro, fo, d;
      dummy = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      check("R1", {up, dn, lead_stb, lag_stb}, 4'b0000, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {up, dn, lead_stb, lag_stb}, 4'b0000, 1);
      repeat (4) @(negedge clk);

      run_case(0, 4, 3, 0, "R2");
      run_case(5, 1, 0, 0, "R5");
      run_case(2, 2, 7, 0, "R6");
      run_case(0, 0, 15, 0, "R4");
      run_case(1, 9, 4, 0, "R7");
      run_case(9, 1, 4, 0, "R7");
      run_case(0, 8, 2, 4, "R8");
      run_case(3, 6, 1, 0, "R9");
      run_case(1, 1, 1, 0, "R11");
      run_case(7, 0, 0, 0, "R3");

      for (int k = 0; k < 40; k++) begin
         ro = int'($urandom_range(0, 8));
         fo = int'($urandom_range(0, 8));
         d  = int'($urandom_range(0, 15));
         run_case(ro, fo, d, 0, "");
      end

      // R10: reference already high when reset is released.
      clr_dly = 4'd2;
      rst_n  = 1'b0;
      ref_in = 1'b1;
      fb_in  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R10", {up, dn, lead_stb, lag_stb}, 4'b1000, 0);
      fb_in = 1'b1;
      repeat (20) @(negedge clk);
      check("R10", {up, dn, lead_stb, lag_stb}, 4'b0000, 1);
      ref_in = 1'b0;
      fb_in  = 1'b0;
      repeat (6) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule